// File: doc/BRIEF.md
# Seven-Instruction Single-Cycle Processor Core

This block is a small processor core that completes every instruction in one clock cycle. It implements seven instructions: register add and subtract, OR with an immediate, word load, word store, branch-if-equal and an absolute jump. A single cycle covers fetch, decode, register read, ALU work, data memory access and write-back, with no pipelining.

The core contains a 32-entry by 32-bit register file, an immediate extender that can be switched between zero and sign extension, a three-function ALU (add, subtract, OR), next-PC selection, an instruction memory and a data memory. Both memories are word arrays. They read combinationally and write on the clock edge.

A loader port fills either memory while the core is held in reset. The core reports each cycle's PC and instruction, and each register or memory write it commits, on observation outputs.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high on a rising edge, the PC becomes 0. While `rst` is high, `reg_we_o` and `mem_we_o` stay low.
- R2: Opcode 0x00 with funct 0x20 writes rs+rt to register rd. Opcode 0x00 with funct 0x22 writes rs−rt to register rd. Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 0x0D zero-extends imm[15:0], ORs it with register rs and writes the result to register rt.
- R4: Opcode 0x23 sign-extends imm[15:0] and adds it to rs to form a byte address. It writes the data memory word at address bits [AW+1:2] to register rt.
- R5: Opcode 0x2B writes register rt to the data memory word addressed the same way as R4. It does not write any register.
- R6: Opcode 0x04 compares rs and rt by subtraction. When they are equal, the next PC is PC+4+(sign-extended imm<<2). Otherwise the next PC is PC+4.
- R7: Opcode 0x02 sets the next PC to {PC+4[31:28], target[25:0], 2'b00}.
- R8: Register 0 always reads as zero. A write aimed at register 0 is discarded and is not reported on `reg_we_o`.
- R9: Any other opcode, or opcode 0x00 with any funct other than 0x20 or 0x22, writes nothing and advances the PC by 4.
- R10: Except for a taken branch or a jump, each non-reset cycle advances the PC by exactly 4.
- R11: When `ld_en` is high on a rising edge, `ld_data` is written to word `ld_addr` of the instruction memory if `ld_sel` is 0, or of the data memory if `ld_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Loader write strobe |
| ld_sel | input | 1 | Loader target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Loader word address |
| ld_data | input | 32 | Loader write data |
| pc_o | output | 32 | Current PC |
| instr_o | output | 32 | Instruction being executed |
| reg_we_o | output | 1 | Register write committed this cycle |
| reg_waddr_o | output | 5 | Register written |
| reg_wdata_o | output | 32 | Value written to the register |
| mem_we_o | output | 1 | Data memory write committed this cycle |
| mem_addr_o | output | 32 | Data memory byte address |
| mem_wdata_o | output | 32 | Value written to data memory |

## Verification
The bench builds the core with 32 instruction words and 16 data words. The program and its data then fill a large share of each array, so a negative store offset lands inside the populated data range. The same program exercises zero-extension of a top-bit-set immediate, a sign-extended negative load offset, a taken and an untaken branch, a jump that skips code, and a self-looping backward branch, all inside a short run. A store of register 0, a write aimed at register 0 and two undecoded words sit between these, so the effects of R8 and R9 are visible at the ports.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;     // write register is rd (else rt)
    logic    use_imm;    // second operand is the immediate
    logic    wb_mem;     // write-back from data memory
    logic    reg_wr;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    logic    sext;       // sign (1) or zero (0) extension
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [31:0] ext16(input logic [15:0] imm, input logic sext);
    return sext ? {{16{imm[15]}}, imm} : {16'h0000, imm};
  endfunction

  function automatic logic [31:0] alu_eval(input alu_op_e op, input logic [31:0] a,
                                           input logic [31:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [31:0] br_target(input logic [31:0] pc4, input logic [15:0] imm);
    return pc4 + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  function automatic logic [31:0] jmp_target(input logic [31:0] pc4, input logic [25:0] tgt);
    return {pc4[31:28], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (op)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_wr = 1'b1;
          ctrl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl.use_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.use_imm = 1'b1;
        ctrl.sext    = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_wr  = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.sext    = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG  = 32,
  parameter int WIDTH = 32,
  localparam int RAW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAW-1:0]   ra_a,
  input  logic [RAW-1:0]   ra_b,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b,
  input  logic             we,
  input  logic [RAW-1:0]   wa,
  input  logic [WIDTH-1:0] wd
);
  logic [WIDTH-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  // R8: entry zero stays zero whatever is written
  p_r0_stays_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> (regs[0] == '0));
  // R2: a committed write is visible on the next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y,
  output logic             zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int WORDS = 64,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] arr [WORDS];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW   = $clog2(IMEM_WORDS),
  localparam int DAW   = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IAW > DAW) ? IAW : DAW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_sel,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [31:0]      pc_o,
  output logic [31:0]      instr_o,
  output logic             reg_we_o,
  output logic [4:0]       reg_waddr_o,
  output logic [31:0]      reg_wdata_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o
);
  logic [31:0] pc_q, pc_next, pc_plus4;
  logic [31:0] instr;
  ctrl_t       ctrl;
  logic [31:0] bus_a, bus_b, imm_ext, alu_b, alu_y, dmem_rd, wb_val;
  logic        alu_zero, br_taken;
  logic [4:0]  waddr;
  logic        reg_commit, mem_commit;
  logic        dm_we;
  logic [DAW-1:0] dm_waddr;
  logic [31:0] dm_wdata;

  // instruction memory: written only by the loader
  sc_mem #(.WORDS(IMEM_WORDS), .WIDTH(32)) u_imem (
    .clk   (clk),
    .we    (ld_en && !ld_sel),
    .waddr (ld_addr[IAW-1:0]),
    .wdata (ld_data),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  sc_decoder u_dec (
    .op    (instr[31:26]),
    .funct (instr[5:0]),
    .ctrl  (ctrl)
  );

  assign waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NREG(32), .WIDTH(32)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (instr[25:21]),
    .ra_b (instr[20:16]),
    .rd_a (bus_a),
    .rd_b (bus_b),
    .we   (reg_commit),
    .wa   (waddr),
    .wd   (wb_val)
  );

  assign imm_ext = ext16(instr[15:0], ctrl.sext);
  assign alu_b   = ctrl.use_imm ? imm_ext : bus_b;

  sc_alu #(.WIDTH(32)) u_alu (
    .op   (ctrl.alu_op),
    .a    (bus_a),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: loader has priority over the core's store
  assign dm_we    = mem_commit || (ld_en && ld_sel);
  assign dm_waddr = (ld_en && ld_sel) ? ld_addr[DAW-1:0] : alu_y[DAW+1:2];
  assign dm_wdata = (ld_en && ld_sel) ? ld_data : bus_b;

  sc_mem #(.WORDS(DMEM_WORDS), .WIDTH(32)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dmem_rd)
  );

  assign wb_val     = ctrl.wb_mem ? dmem_rd : alu_y;
  assign reg_commit = ctrl.reg_wr && !rst && (waddr != 5'd0);
  assign mem_commit = ctrl.mem_wr && !rst;

  // next-PC selection
  assign pc_plus4 = pc_q + 32'd4;
  assign br_taken = ctrl.branch && alu_zero;
  always_comb begin
    if (ctrl.jump)    pc_next = jmp_target(pc_plus4, instr[25:0]);
    else if (br_taken) pc_next = br_target(pc_plus4, instr[15:0]);
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o        = pc_q;
  assign instr_o     = instr;
  assign reg_we_o    = reg_commit;
  assign reg_waddr_o = waddr;
  assign reg_wdata_o = wb_val;
  assign mem_we_o    = mem_commit;
  assign mem_addr_o  = alu_y;
  assign mem_wdata_o = bus_b;

  // ---------------- assertions ----------------
  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= rst;
  always @(negedge clk) begin
    if (rst_seen_q === 1'b1)
      p_pc_reset_r1: assert (pc_q == 32'd0);
  end

  p_no_write_in_reset_r1: assert property (@(posedge clk)
    rst |-> (!reg_we_o && !mem_we_o));
  p_store_no_regwr_r5: assert property (@(posedge clk) disable iff (rst)
    mem_commit |-> !reg_commit);
  p_beq_equal_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && bus_a == bus_b) |-> br_taken);
  p_seq_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!br_taken && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4));
  p_one_effect_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.reg_wr, ctrl.mem_wr, ctrl.branch, ctrl.jump}));
  p_pc_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int IW = 32;
  localparam int DW = 16;
  localparam int LAW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_sel = 1'b0;
  logic [LAW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, instr_o, reg_wdata_o, mem_addr_o, mem_wdata_o;
  logic reg_we_o, mem_we_o;
  logic [4:0] reg_waddr_o;

  always #10 clk = ~clk;  // 50 MHz

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o), .reg_we_o(reg_we_o),
    .reg_waddr_o(reg_waddr_o), .reg_wdata_o(reg_wdata_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  typedef struct {
    logic [31:0] pc;
    logic        rwe;
    logic [4:0]  ra;
    logic [31:0] rd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] md;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit run_go = 0, done = 0;

  logic [31:0] prog [IW];
  logic [31:0] mdl_mem [DW];
  logic [31:0] mdl_reg [32];
  logic [31:0] mdl_pc;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference step: computes one instruction's expected effect and pushes it
  task automatic model_step();
    exp_t e;
    logic [31:0] w, a, b, simm, nxt;
    logic [5:0] op, fn;
    w  = prog[mdl_pc[6:2]];
    op = w[31:26]; fn = w[5:0];
    a  = mdl_reg[w[25:21]]; b = mdl_reg[w[20:16]];
    simm = {{16{w[15]}}, w[15:0]};
    nxt = mdl_pc + 4;
    e = '{pc: mdl_pc, rwe: 0, ra: 0, rd: 0, mwe: 0, ma: 0, md: 0, tag: "R9"};
    if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22)) begin
      e.ra = w[15:11]; e.rd = (fn == 6'h20) ? a + b : a - b; e.rwe = 1; e.tag = "R2";
    end else if (op == 6'h0D) begin
      e.ra = w[20:16]; e.rd = a | {16'h0, w[15:0]}; e.rwe = 1; e.tag = "R3";
    end else if (op == 6'h23) begin
      e.ra = w[20:16]; e.rd = mdl_mem[(a + simm) >> 2]; e.rwe = 1; e.tag = "R4";
    end else if (op == 6'h2B) begin
      e.mwe = 1; e.ma = a + simm; e.md = b; e.tag = "R5";
      mdl_mem[(a + simm) >> 2] = b;
    end else if (op == 6'h04) begin
      e.tag = "R6";
      if (a == b) nxt = mdl_pc + 4 + (simm << 2);
    end else if (op == 6'h02) begin
      e.tag = "R7";
      nxt = {nxt[31:28], w[25:0], 2'b00};
    end
    if (e.rwe && e.ra == 5'd0) begin
      e.rwe = 0; e.tag = "R8";
    end
    if (e.rwe) mdl_reg[e.ra] = e.rd;
    q.push_back(e);
    mdl_pc = nxt;
  endtask

  task automatic load_word(logic sel, int addr, logic [31:0] data);
    @(negedge clk);
    ld_en = 1; ld_sel = sel; ld_addr = LAW'(addr); ld_data = data;
    @(negedge clk);
    ld_en = 0;
  endtask

  // driver
  initial begin
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    for (int i = 0; i < DW; i++) mdl_mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) mdl_reg[i] = 32'h0;
    prog[0]  = enc_i(6'h0D, 0, 1, 16'h8000);  // R3 top bit set, zero-extended
    prog[1]  = enc_i(6'h0D, 0, 2, 16'h0010);
    prog[2]  = enc_i(6'h23, 2, 3, 0);          // R4
    prog[3]  = enc_i(6'h23, 2, 4, 4);
    prog[4]  = enc_r(3, 4, 5, 6'h20);          // R2 add
    prog[5]  = enc_r(3, 4, 6, 6'h22);          // R2 sub
    prog[6]  = enc_i(6'h2B, 2, 5, 16'hFFF8);   // R5 negative offset
    prog[7]  = enc_i(6'h23, 2, 7, 16'hFFF8);
    prog[8]  = enc_r(1, 2, 0, 6'h20);          // R8 write to r0 dropped
    prog[9]  = enc_i(6'h2B, 0, 0, 12);         // R8 r0 reads zero
    prog[10] = enc_i(6'h04, 5, 7, 2);          // R6 taken
    prog[11] = enc_i(6'h0D, 0, 9, 16'h1111);
    prog[12] = enc_i(6'h0D, 0, 9, 16'h2222);
    prog[13] = enc_i(6'h04, 1, 2, 5);          // R6 not taken
    prog[14] = 32'hFC00_0000;                  // R9 unknown opcode
    prog[15] = enc_r(1, 2, 11, 6'h25);         // R9 unsupported funct
    prog[16] = {6'h02, 26'd20};                // R7
    prog[17] = enc_i(6'h0D, 0, 10, 16'h3333);
    prog[18] = enc_i(6'h0D, 0, 10, 16'h4444);
    prog[19] = enc_i(6'h0D, 0, 10, 16'h5555);
    prog[20] = enc_r(2, 2, 8, 6'h22);
    prog[21] = enc_i(6'h04, 0, 0, 16'hFFFF);   // R6 backward, self-loop
    mdl_mem[4] = 32'h1234_5678;
    mdl_mem[5] = 32'hFFFF_FFF0;

    repeat (2) @(negedge clk);
    // R11: fill both memories through the loader while in reset
    for (int i = 0; i < 22; i++) load_word(1'b0, i, prog[i]);
    load_word(1'b1, 4, mdl_mem[4]);
    load_word(1'b1, 5, mdl_mem[5]);
    @(negedge clk); #1;
    check("R1", "reset pc", pc_o, 32'h0);
    check("R1", "reset reg_we", {31'h0, reg_we_o}, 32'h0);
    check("R1", "reset mem_we", {31'h0, mem_we_o}, 32'h0);
    check("R11", "first fetched word", instr_o, prog[0]);

    mdl_pc = 0;
    for (int k = 0; k < 26; k++) model_step();
    @(negedge clk);
    rst = 0;
    run_go = 1;
  end

  // monitor
  initial begin
    exp_t e;
    wait (run_go);
    while (q.size() > 0) begin
      #1;
      e = q.pop_front();
      check(e.tag, "pc (R10)", pc_o, e.pc);
      check(e.tag, "reg_we", {31'h0, reg_we_o}, {31'h0, e.rwe});
      if (e.rwe) begin
        check(e.tag, "reg_waddr", {27'h0, reg_waddr_o}, {27'h0, e.ra});
        check(e.tag, "reg_wdata", reg_wdata_o, e.rd);
      end
      check(e.tag, "mem_we", {31'h0, mem_we_o}, {31'h0, e.mwe});
      if (e.mwe) begin
        check(e.tag, "mem_addr", mem_addr_o, e.ma);
        check(e.tag, "mem_wdata", mem_wdata_o, e.md);
      end
      @(negedge clk);
    end
    done = 1;
  end

  // watchdog and summary
  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule